// File: doc/BRIEF.md
# Dual-Bank Level-Sensitive Data Latch

This block holds two independent banks of data, nine bits each by default. Each bank has its own active-high load enable and its own active-low output enable. While the load enable is high the bank is transparent, so its output tracks its input in the same cycle. While the load enable is low, the bank keeps the word it last captured. Nothing here is a true latch. Each bank keeps its word in a register clocked by the system clock, with a combinational bypass for the transparent phase. The block therefore builds from flip-flops alone and times like any other synchronous logic.

Each output is a data word plus a drive flag. A low drive flag means the output is high impedance, and the data word is then forced to zero. After reset both banks stay undriven, even when the output enable is already low. A bank starts driving only after its output enable has been seen high at one clock edge and low at a later one. From then on the drive flag follows the output enable directly until the next reset. The output enable never affects loading, so a word can be loaded while its bank is silent and read out later. The reset input is asynchronous and active low. Its release is synchronized to the clock inside the block.

Top module: `dual_bank_latch`

## Requirements
- R1: While reset is asserted, and from reset until a bank is armed, that bank's drive flag is 0 and its data word reads all zeros. Asserting the reset input clears the drive flags at once, without waiting for a clock edge.
- R2: When a bank is driving and its load enable is 1, its data word equals its data input in the same cycle.
- R3: When a bank's load enable is 0, its data word (when driven) equals the input value sampled at the last rising clock edge at which that load enable was 1. Input changes between that edge and the fall of load enable are not kept.
- R4: When a bank's output enable is 1 (inactive), that bank's drive flag is 0 and its data word is zero.
- R5: A bank loads new data whether its output enable is 1 or 0. A word captured while the bank was not driving appears on the data word once the bank drives again.
- R6: After reset, a bank drives only after its output enable has been sampled 1 at one rising edge and 0 at a later one. An output enable held at 0 straight out of reset leaves the bank undriven. The drive flag first rises in the cycle after the edge at which the 0 is sampled.
- R7: Once armed, a bank's drive flag equals the inverse of its output enable in every cycle until the next reset.
- R8: The two banks are independent. Bit slice [8:0] of the packed data and control vectors is bank 0, and bit slice [17:9] (control bit 1) is bank 1. One bank's controls never alter the other bank's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_din | input | 18 | Packed data inputs, bank 0 in [8:0], bank 1 in [17:9] |
| bank_load | input | 2 | Per-bank active-high load (transparent) enable |
| bank_oe_n | input | 2 | Per-bank active-low output enable |
| bank_dout | output | 18 | Packed data outputs, zero when the bank is not driving |
| bank_drive | output | 2 | Per-bank drive flag, 1 means driven and 0 means high impedance |

## Verification
The hardest state to reach is the one just after reset. Here the output enable is already low, yet the bank must stay silent, and it must begin driving only after a genuine high-to-low sequence. The stimulus leaves the output enables low through reset and release and confirms that nothing drives. It then raises one bank's enable for a single edge and lowers it again, checking that the drive flag stays 0 before the arming edge and is 1 after it. The other bank is still unarmed at that point, which shows the two banks are independent. A second reset in mid-run repeats this sequence from a state that had been driving.

// File: rtl/dual_bank_latch_pkg.sv
package dual_bank_latch_pkg;

  localparam int unsigned DEF_BANKS = 2;
  localparam int unsigned DEF_WIDTH = 9;

  typedef enum logic {
    ARM_WAIT = 1'b0,
    ARM_LIVE = 1'b1
  } arm_state_e;

endpackage

// File: rtl/dual_bank_latch_rst_sync.sv
module dual_bank_latch_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dual_bank_latch_arm.sv
module dual_bank_latch_arm
  import dual_bank_latch_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic oe_n,
  output logic drive
);

  arm_state_e state_q, state_d;
  logic       was_off_q, was_off_d;

  always_comb begin
    was_off_d = oe_n;
    state_d   = state_q;
    if ((state_q == ARM_WAIT) && was_off_q && !oe_n) begin
      state_d = ARM_LIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ARM_WAIT;
      was_off_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      was_off_q <= was_off_d;
    end
  end

  assign drive = (state_q == ARM_LIVE) && !oe_n;

endmodule

// File: rtl/dual_bank_latch_store.sv
module dual_bank_latch_store #(
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din,
  input  logic             load,
  input  logic             drive,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] held_q, held_d;
  logic [WIDTH-1:0] view;

  always_comb begin
    held_d = held_q;
    if (load) begin
      held_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
    end else begin
      held_q <= held_d;
    end
  end

  always_comb begin
    view = load ? din : held_q;
    dout = drive ? view : '0;
  end

endmodule

// File: rtl/dual_bank_latch.sv
module dual_bank_latch
  import dual_bank_latch_pkg::*;
#(
  parameter int unsigned BANKS = DEF_BANKS,
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned SYNC  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BANKS*WIDTH-1:0] bank_din,
  input  logic [BANKS-1:0]       bank_load,
  input  logic [BANKS-1:0]       bank_oe_n,
  output logic [BANKS*WIDTH-1:0] bank_dout,
  output logic [BANKS-1:0]       bank_drive
);

  localparam int unsigned BUS_W = BANKS * WIDTH;

  logic             rst_int_n;
  logic [BUS_W-1:0] dout_w;
  logic [BANKS-1:0] drive_w;

  dual_bank_latch_rst_sync #(.STAGES(SYNC)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    dual_bank_latch_arm u_arm (
      .clk    (clk),
      .rst_ni (rst_int_n),
      .oe_n   (bank_oe_n[b]),
      .drive  (drive_w[b])
    );

    dual_bank_latch_store #(.WIDTH(WIDTH)) u_store (
      .clk    (clk),
      .rst_ni (rst_int_n),
      .din    (bank_din[b*WIDTH +: WIDTH]),
      .load   (bank_load[b]),
      .drive  (drive_w[b]),
      .dout   (dout_w[b*WIDTH +: WIDTH])
    );
  end

  assign bank_dout  = dout_w;
  assign bank_drive = drive_w;

endmodule

// File: rtl/dual_bank_latch_chk.sv
module dual_bank_latch_chk #(
  parameter int unsigned BANKS = 2,
  parameter int unsigned WIDTH = 9
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [BANKS*WIDTH-1:0] bank_din,
  input logic [BANKS-1:0]       bank_load,
  input logic [BANKS-1:0]       bank_oe_n,
  input logic [BANKS*WIDTH-1:0] bank_dout,
  input logic [BANKS-1:0]       bank_drive
);

  logic [BANKS-1:0] seen_off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_off_q <= '0;
    end else begin
      seen_off_q <= seen_off_q | bank_oe_n;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_chk
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      bank_oe_n[b] |-> (!bank_drive[b] && (bank_dout[b*WIDTH +: WIDTH] == '0))); // R4

    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_drive[b] |-> (bank_dout[b*WIDTH +: WIDTH] == '0)); // R1

    AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_load[b] && bank_drive[b]) |->
        (bank_dout[b*WIDTH +: WIDTH] == bank_din[b*WIDTH +: WIDTH])); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bank_load[b] && $past(!bank_load[b]) && bank_drive[b] && $past(bank_drive[b]))
        |-> $stable(bank_dout[b*WIDTH +: WIDTH])); // R3

    AST_ARM_NEEDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      bank_drive[b] |-> seen_off_q[b]); // R6

    AST_STAY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bank_drive[b]) && !bank_oe_n[b]) |-> bank_drive[b]); // R7
  end

endmodule

bind dual_bank_latch dual_bank_latch_chk #(.BANKS(BANKS), .WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bank_din   (bank_din),
  .bank_load  (bank_load),
  .bank_oe_n  (bank_oe_n),
  .bank_dout  (bank_dout),
  .bank_drive (bank_drive)
);

// File: tb/dual_bank_latch_bench.sv
`timescale 1ns/1ps
module dual_bank_latch_bench;

  localparam int W = 9;
  localparam int NV = 10;

  logic          clk;
  logic          rst_n;
  logic [2*W-1:0] din;
  logic [1:0]    load;
  logic [1:0]    oe_n;
  logic [2*W-1:0] dout;
  logic [1:0]    drive;

  int n_checks = 0;
  int n_fails  = 0;

  dual_bank_latch u_dual_bank_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_din   (din),
    .bank_load  (load),
    .bank_oe_n  (oe_n),
    .bank_dout  (dout),
    .bank_drive (drive)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: load, oe_n, din_b, din_a, exp_b, exp_a, exp_drive
  localparam logic [41:0] VEC [NV] = '{
    {2'b11, 2'b00, 9'h05A, 9'h1A5, 9'h05A, 9'h1A5, 2'b11}, // R2 both transparent
    {2'b01, 2'b00, 9'h1FF, 9'h0F0, 9'h05A, 9'h0F0, 2'b11}, // R3 R8 B holds
    {2'b00, 2'b00, 9'h122, 9'h111, 9'h05A, 9'h0F0, 2'b11}, // R3 both hold
    {2'b10, 2'b01, 9'h144, 9'h033, 9'h144, 9'h000, 2'b10}, // R4 R8 A silent
    {2'b01, 2'b01, 9'h000, 9'h1C3, 9'h144, 9'h000, 2'b10}, // R5 load A while silent
    {2'b00, 2'b00, 9'h000, 9'h000, 9'h144, 9'h1C3, 2'b11}, // R5 loaded word appears
    {2'b00, 2'b11, 9'h1FF, 9'h1FF, 9'h000, 9'h000, 2'b00}, // R4 both silent
    {2'b00, 2'b10, 9'h1FF, 9'h1FF, 9'h000, 9'h1C3, 2'b01}, // R7 A returns at once
    {2'b11, 2'b00, 9'h100, 9'h1FF, 9'h100, 9'h1FF, 2'b11}, // R2 R7
    {2'b00, 2'b00, 9'h000, 9'h000, 9'h100, 9'h1FF, 2'b11}  // R3
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [2*W-1:0] exp_d,
                           input logic [1:0] exp_v);
    check(dout == exp_d, req, 32'(dout), 32'(exp_d));
    check(drive == exp_v, req, 32'(drive), 32'(exp_v));
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    din   = '0;
    load  = 2'b00;
    oe_n  = 2'b00;
    repeat (3) @(negedge clk);
    #1 check_out("R1 in reset", '0, 2'b00);

    // R6: enable low straight out of reset must not arm
    @(negedge clk);
    rst_n = 1'b1;
    load  = 2'b11;
    din   = {9'h0AB, 9'h0CD};
    repeat (5) @(negedge clk);
    #1 check_out("R6 no arm without high phase", '0, 2'b00);

    // arm bank A only
    @(negedge clk);
    oe_n = 2'b01;
    @(negedge clk);
    oe_n = 2'b00;
    #1 check_out("R6 not before arming edge", '0, 2'b00);
    @(negedge clk);
    #1 check_out("R6 R8 A armed B idle", {9'h000, 9'h0CD}, 2'b01);

    // arm bank B
    @(negedge clk);
    oe_n = 2'b10;
    @(negedge clk);
    oe_n = 2'b00;
    @(negedge clk);
    #1 check_out("R6 B armed", {9'h0AB, 9'h0CD}, 2'b11);

    // R3: change during transparent phase without an edge is not kept
    @(negedge clk);
    din = {9'h0AB, 9'h0AA};
    @(negedge clk);
    din = {9'h0AB, 9'h155};
    #1 check_out("R2 follows input", {9'h0AB, 9'h155}, 2'b11);
    #1 load = 2'b00;
    #1 check_out("R3 last edge value kept", {9'h0AB, 9'h0AA}, 2'b11);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      load = VEC[i][41:40];
      oe_n = VEC[i][39:38];
      din  = VEC[i][37:20];
      #1 check_out($sformatf("vector %0d", i), VEC[i][19:2], VEC[i][1:0]);
    end

    // R1: reset in mid-run clears drive at once, R6: re-arm required
    @(negedge clk);
    rst_n = 1'b0;
    #1 check_out("R1 async clear", '0, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    load  = 2'b00;
    oe_n  = 2'b00;
    repeat (4) @(negedge clk);
    #1 check_out("R6 idle after second reset", '0, 2'b00);
    oe_n = 2'b11;
    @(negedge clk);
    oe_n = 2'b00;
    @(negedge clk);
    #1 check_out("R1 R6 rearmed word cleared", '0, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule